// File: doc/BRIEF.md
# Management-Mode Base Relocation Unit

This block keeps the base address of the system-management memory region and derives from it every address the processor needs when it takes a management interrupt. From the base it forms four addresses: the handler entry vector, the top and bottom of the state-save region, and the slot where the current base is written during entry. It also reports a revision identifier whose relocation-capable flag is always set.

Software relocates the region by writing a new value into the base slot while the handler runs. When the resume instruction executes, the value read back from that slot is presented on `slot_rdata_i` together with a one-cycle `resume_i` strobe. A value aligned to 32 KB becomes the new base on the next clock edge, and the next interrupt uses it. A value that is not aligned is discarded and a shutdown request is raised. That request holds until reset, and while it is raised the block ignores both entry and resume strobes.

Top module: `smm_base_reloc`

## Requirements
- R1: While reset is active, and on the first edge after it, the base reads 0x0003_0000 and `shutdown_o` is low.
- R2: `entry_vec_o` equals the base plus 0x8000.
- R3: `save_top_o` equals the base plus 0xFFFF and `save_bot_o` equals the base plus 0x8000; the save region runs downward from the top.
- R4: `slot_addr_o` equals the base plus 0xFEF8. `slot_we_o` is high in the same cycle as `smi_entry_i` whenever no shutdown is pending.
- R5: A `resume_i` strobe whose `slot_rdata_i` has bits 14:0 all zero loads that value as the base on the next clock edge. All derived addresses follow from then on.
- R6: A `resume_i` strobe whose `slot_rdata_i` has any of bits 14:0 set raises `shutdown_o` on the next edge and leaves the base unchanged.
- R7: `shutdown_o` stays high until reset. While it is high, `smi_entry_i` does not raise `slot_we_o` and `resume_i` does not change the base.
- R8: The base changes only on an accepted resume. An entry strobe leaves it unchanged.
- R9: Bit 17 of `rev_id_o` is always 1.
- R10: All address sums wrap modulo 2^32. For a base of 0xFFFF_8000 the entry vector is 0x0000_0000, the save top is 0x0000_7FFF and the slot is 0x0000_7EF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smi_entry_i | input | 1 | One-cycle strobe: management interrupt being taken |
| resume_i | input | 1 | One-cycle strobe: resume instruction executing |
| slot_rdata_i | input | 32 | Base-slot value read back during resume |
| base_o | output | 32 | Current base |
| entry_vec_o | output | 32 | Handler entry address |
| save_top_o | output | 32 | Highest address of the state-save region |
| save_bot_o | output | 32 | Lowest address of the state-save region |
| slot_addr_o | output | 32 | Address of the base slot |
| slot_we_o | output | 1 | Request to write the base into the slot on entry |
| shutdown_o | output | 1 | Sticky shutdown request after a misaligned resume |
| rev_id_o | output | 32 | Revision identifier with the relocation flag set |

## Verification
The load and fault properties assume that `slot_rdata_i` is valid in the same cycle as `resume_i`. They also assume that each strobe lasts one cycle and is separated from the next by idle cycles. The directed tasks drive every strobe on a falling edge together with its data and drop it on the following falling edge, so the data is stable across the sampling edge. No task raises both strobes in the same cycle. Reset is held low from time zero, so the reset-value property never sees unknown inputs.

// File: rtl/smm_reloc_pkg.sv
package smm_reloc_pkg;
  localparam int unsigned ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;

  // Sum of a base and an offset, wrapping modulo 2^ADDR_W.
  function automatic addr_t add_ofs(input addr_t base, input addr_t ofs);
    return base + ofs;
  endfunction

  // True when no bit below the alignment boundary is set.
  function automatic logic is_aligned(input addr_t value, input int unsigned lo_bits);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < int'(lo_bits); i++) begin
      if (value[i]) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/smm_align_chk.sv
module smm_align_chk #(
  parameter int unsigned LO_BITS = 15
) (
  input  logic [LO_BITS-1:0] low_i,
  output logic               aligned_o
);
  assign aligned_o = ~|low_i;
endmodule

// File: rtl/smm_base_reg.sv
module smm_base_reg #(
  parameter int unsigned AW       = 32,
  parameter logic [AW-1:0] RST_BASE = 32'h0003_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          fault_i,
  input  logic [AW-1:0] value_i,
  output logic [AW-1:0] base_o,
  output logic          shutdown_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_o     <= RST_BASE;
      shutdown_o <= 1'b0;
    end else begin
      if (load_i)  base_o     <= value_i;
      if (fault_i) shutdown_o <= 1'b1;
    end
  end
endmodule

// File: rtl/smm_addr_gen.sv
module smm_addr_gen
  import smm_reloc_pkg::*;
#(
  parameter addr_t ENTRY_OFS = 32'h0000_8000,
  parameter addr_t SPAN_OFS  = 32'h0000_7FFF,
  parameter addr_t SLOT_OFS  = 32'h0000_7EF8
) (
  input  addr_t base_i,
  output addr_t entry_o,
  output addr_t top_o,
  output addr_t bot_o,
  output addr_t slot_o
);
  localparam addr_t TOP_OFS  = ENTRY_OFS + SPAN_OFS;
  localparam addr_t SLOT_ABS = ENTRY_OFS + SLOT_OFS;

  assign entry_o = add_ofs(base_i, ENTRY_OFS);
  assign bot_o   = add_ofs(base_i, ENTRY_OFS);
  assign top_o   = add_ofs(base_i, TOP_OFS);
  assign slot_o  = add_ofs(base_i, SLOT_ABS);
endmodule

// File: rtl/smm_base_reloc.sv
module smm_base_reloc
  import smm_reloc_pkg::*;
#(
  parameter int unsigned ALIGN_BITS = 15,
  parameter addr_t RST_BASE  = 32'h0003_0000,
  parameter addr_t ENTRY_OFS = 32'h0000_8000,
  parameter addr_t SPAN_OFS  = 32'h0000_7FFF,
  parameter addr_t SLOT_OFS  = 32'h0000_7EF8,
  parameter addr_t REV_BASE  = 32'h0000_0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smi_entry_i,
  input  logic        resume_i,
  input  logic [31:0] slot_rdata_i,
  output logic [31:0] base_o,
  output logic [31:0] entry_vec_o,
  output logic [31:0] save_top_o,
  output logic [31:0] save_bot_o,
  output logic [31:0] slot_addr_o,
  output logic        slot_we_o,
  output logic        shutdown_o,
  output logic [31:0] rev_id_o
);
  localparam int unsigned RELOC_FLAG_BIT = 17;
  localparam addr_t REV_ID = REV_BASE | (addr_t'(1) << RELOC_FLAG_BIT);

  // Named internal events, observed by the bound checker.
  logic resume_ok;
  logic slot_aligned;
  logic load_ok;
  logic bad_align;

  assign resume_ok = resume_i & ~shutdown_o;
  assign load_ok   = resume_ok &  slot_aligned;
  assign bad_align = resume_ok & ~slot_aligned;

  smm_align_chk #(.LO_BITS(ALIGN_BITS)) u_align (
    .low_i     (slot_rdata_i[ALIGN_BITS-1:0]),
    .aligned_o (slot_aligned)
  );

  smm_base_reg #(.AW(ADDR_W), .RST_BASE(RST_BASE)) u_base (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_ok),
    .fault_i    (bad_align),
    .value_i    (slot_rdata_i),
    .base_o     (base_o),
    .shutdown_o (shutdown_o)
  );

  smm_addr_gen #(.ENTRY_OFS(ENTRY_OFS), .SPAN_OFS(SPAN_OFS), .SLOT_OFS(SLOT_OFS)) u_addr (
    .base_i  (base_o),
    .entry_o (entry_vec_o),
    .top_o   (save_top_o),
    .bot_o   (save_bot_o),
    .slot_o  (slot_addr_o)
  );

  assign slot_we_o = smi_entry_i & ~shutdown_o;
  assign rev_id_o  = REV_ID;
endmodule

// File: rtl/smm_reloc_chk.sv
module smm_reloc_chk #(
  parameter int unsigned ALIGN_BITS = 15,
  parameter logic [31:0] RST_BASE   = 32'h0003_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        smi_entry_i,
  input logic        resume_i,
  input logic [31:0] slot_rdata_i,
  input logic [31:0] base_o,
  input logic        slot_we_o,
  input logic        shutdown_o,
  input logic        load_ok,
  input logic        bad_align
);
  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (base_o == RST_BASE && !shutdown_o));

  // R5: accepted aligned value becomes the base
  a_r5_aligned_load: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_i && !shutdown_o && slot_rdata_i[ALIGN_BITS-1:0] == '0)
      |=> base_o == $past(slot_rdata_i));

  // R6: misaligned value faults and is not loaded
  a_r6_misaligned_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_i && !shutdown_o && slot_rdata_i[ALIGN_BITS-1:0] != '0)
      |=> (shutdown_o && $stable(base_o)));

  // R7: shutdown is sticky
  a_r7_shutdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_o |=> shutdown_o);

  // R7: entry ignored while shut down
  a_r7_no_entry_write: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_o && smi_entry_i) |-> !slot_we_o);

  // R8: base holds without an accepted resume
  a_r8_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ok |=> $stable(base_o));

  // R6: load and fault never together
  a_r6_excl_events: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_ok && bad_align));

  // R5: base stays aligned
  a_r5_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    base_o[ALIGN_BITS-1:0] == '0);
endmodule

bind smm_base_reloc smm_reloc_chk #(.ALIGN_BITS(ALIGN_BITS), .RST_BASE(RST_BASE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .smi_entry_i  (smi_entry_i),
  .resume_i     (resume_i),
  .slot_rdata_i (slot_rdata_i),
  .base_o       (base_o),
  .slot_we_o    (slot_we_o),
  .shutdown_o   (shutdown_o),
  .load_ok      (load_ok),
  .bad_align    (bad_align)
);

// File: tb/smm_base_reloc_tb.sv
module smm_base_reloc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smi_entry_i = 1'b0;
  logic        resume_i = 1'b0;
  logic [31:0] slot_rdata_i = '0;
  logic [31:0] base_o, entry_vec_o, save_top_o, save_bot_o, slot_addr_o, rev_id_o;
  logic        slot_we_o, shutdown_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  smm_base_reloc u_dut (
    .clk(clk), .rst_n(rst_n), .smi_entry_i(smi_entry_i), .resume_i(resume_i),
    .slot_rdata_i(slot_rdata_i), .base_o(base_o), .entry_vec_o(entry_vec_o),
    .save_top_o(save_top_o), .save_bot_o(save_bot_o), .slot_addr_o(slot_addr_o),
    .slot_we_o(slot_we_o), .shutdown_o(shutdown_o), .rev_id_o(rev_id_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected addresses restated from the requirements.
  task automatic chk_addrs(input string req, input logic [31:0] b);
    chk({req, " base"},  base_o, b);
    chk({req, " entry"}, entry_vec_o, b + 32'd32768);
    chk({req, " top"},   save_top_o, b + 32'd65535);
    chk({req, " bot"},   save_bot_o, b + 32'd32768);
    chk({req, " slot"},  slot_addr_o, b + 32'd65272);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic do_resume(input logic [31:0] v);
    @(negedge clk); resume_i = 1'b1; slot_rdata_i = v;
    @(negedge clk); resume_i = 1'b0; slot_rdata_i = 32'hDEAD_BEEF;
  endtask

  task automatic t_reset();
    chk("R1 shutdown", {31'd0, shutdown_o}, 32'd0);
    chk_addrs("R1/R2/R3/R4 default", 32'h0003_0000);
    chk("R9 rev flag", {31'd0, rev_id_o[17]}, 32'd1);
  endtask

  task automatic t_entry();
    @(negedge clk); smi_entry_i = 1'b1; #1;
    chk("R4 slot_we", {31'd0, slot_we_o}, 32'd1);
    chk("R4 slot addr", slot_addr_o, 32'h0003_FEF8);
    @(negedge clk); smi_entry_i = 1'b0; #1;
    chk("R4 slot_we drop", {31'd0, slot_we_o}, 32'd0);
    chk("R8 base after entry", base_o, 32'h0003_0000);
  endtask

  task automatic t_relocate();
    do_resume(32'h0010_0000);
    chk_addrs("R5 relocate", 32'h0010_0000);
    do_resume(32'h00AB_8000);
    chk_addrs("R5 relocate odd 32K", 32'h00AB_8000);
    repeat (3) @(negedge clk);
    chk("R8 idle hold", base_o, 32'h00AB_8000);
  endtask

  task automatic t_wrap();
    do_resume(32'hFFFF_8000);
    chk("R10 entry", entry_vec_o, 32'h0000_0000);
    chk("R10 top", save_top_o, 32'h0000_7FFF);
    chk("R10 slot", slot_addr_o, 32'h0000_7EF8);
    chk("R10 base", base_o, 32'hFFFF_8000);
  endtask

  task automatic t_misaligned(input logic [31:0] v, input logic [31:0] prev);
    do_resume(v);
    chk("R6 shutdown", {31'd0, shutdown_o}, 32'd1);
    chk("R6 base kept", base_o, prev);
  endtask

  task automatic t_sticky(input logic [31:0] prev);
    do_resume(32'h0020_0000);
    chk("R7 resume ignored", base_o, prev);
    @(negedge clk); smi_entry_i = 1'b1; #1;
    chk("R7 entry ignored", {31'd0, slot_we_o}, 32'd0);
    @(negedge clk); smi_entry_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 still shut", {31'd0, shutdown_o}, 32'd1);
  endtask

  initial begin
    fork
      begin
        do_reset();
        t_reset();
        t_entry();
        t_relocate();
        t_wrap();
        t_misaligned(32'h0004_0001, 32'hFFFF_8000);
        t_sticky(32'hFFFF_8000);
        do_reset();
        t_reset();
        t_misaligned(32'h0005_4000, 32'h0003_0000);
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule